// File: doc/BRIEF.md
# Activity-Counter Power Estimator

This block watches up to a few dozen single-cycle activity strobes from a processor core. Examples are register-file reads, cache lookups and multiplies. It keeps one saturating tally per strobe. Software runs the tallies with start, stop and clear commands written to a control word, and reads every tally over a simple word-addressed read/write bus while counting goes on.

Beside the raw tallies, the block forms an energy estimate in hardware. Every cycle that counting is enabled, a programmable static weight is added; this weight stands for leakage plus clock power that is not gated. A single multiplier takes one event per cycle in a fixed rotation. It multiplies the growth of that event's tally since its last turn by the event's programmable weight and folds the product into a 64-bit total. A periodic timer handler samples the total as two 32-bit halves. Reading the low half freezes a copy of the high half, so the two halves form one coherent value.

Top module: `act_power_est`

## Requirements
- R1: While running, each cycle with `evt_i[i]` high raises tally i by exactly one. Tallies are independent of each other.
- R2: A tally that reaches all ones (2^CNT_W-1) holds there and does not wrap.
- R3: A write to offset 0x00 acts on the set bits: bit 0 starts, bit 1 stops and bit 2 clears. Stop wins over start. Clear zeroes all tallies and the energy total without changing the run state, so writing 0x5 clears and then counts from the next cycle.
- R4: While stopped, event strobes are ignored, and the tallies and energy total do not change.
- R5: A read of offset 0x04 returns the run state in bit 0 (1 = running), with the other bits zero.
- R6: A read of offset 0x100+4*i returns tally i, zero-extended. Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.
- R7: Offset 0x200+4*i holds the 16-bit weight of event i, and 0x200+4*NUM_EVT holds the static weight. All weights are writable and readable and reset to zero.
- R8: After counting has run for at least NUM_EVT+1 cycles with no strobes, the energy total equals static weight × (cycles run since the last clear) plus the sum over i of tally i × weight i.
- R9: Reading 0x300 returns energy bits 31:0 and copies bits 63:32 into a holding word. Reading 0x304 returns that holding word, which only a read of 0x300 changes.
- R10: Reads of the control word and of any offset not listed above return zero.
- R11: After hardware reset, the block is stopped, and all tallies, weights and the energy total are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | One activity strobe per event |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte offset, word aligned |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |

## Verification
Several corner cases are targeted, each with the failure it would expose:
- **Saturation.** The bench drives every tally past its ceiling. A wrapping counter would read back a small value instead of all ones.
- **Command overlap.** Start is combined with stop, and with clear. Wrong priority would leave the block running, or would keep a stale tally or count the strobe in the clear cycle.
- **Stopped strobes.** Strobes arrive while stopped. A leaky gate would move the tallies or the total.
- **Energy halves.** The total is driven past 2^32 and a clear is placed between the low and high reads. A design that reads the live high half, or that clears the holding word, returns a torn pair.
- **Round-robin drain.** The weighted total is compared after the rotation has drained. A lost or doubled delta, or a static term counted on the wrong cycles, gives a different sum.

// File: rtl/act_power_est.sv
module act_power_est #(
  parameter int NUM_EVT = 36,
  parameter int CNT_W   = 32,
  parameter int WGT_W   = 16,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int ACC_W  = 2 * DATA_W;
  localparam int IDX_W  = $clog2(NUM_EVT);
  localparam int PROD_W = CNT_W + WGT_W;
  localparam int SLOT_W = 6;
  localparam int REG_W  = ADDR_W - 8;

  logic                              running_q;
  logic [NUM_EVT-1:0][CNT_W-1:0]     cnt_q;
  logic [NUM_EVT-1:0][CNT_W-1:0]     seen_q;
  logic [NUM_EVT:0][WGT_W-1:0]       wgt_q;
  logic [IDX_W-1:0]                  rr_q;
  logic [PROD_W-1:0]                 prod_q;
  logic [ACC_W-1:0]                  acc_q;
  logic [DATA_W-1:0]                 hi_hold_q;
  logic [DATA_W-1:0]                 rdata_q;

  wire [REG_W-1:0]  region = addr[ADDR_W-1:8];
  wire [SLOT_W-1:0] slot   = addr[7:2];
  wire ctl_wr    = wr_en && region == REG_W'(0) && slot == SLOT_W'(0);
  wire cmd_start = ctl_wr && wdata[0];
  wire cmd_stop  = ctl_wr && wdata[1];
  wire cmd_clr   = ctl_wr && wdata[2];

  wire [CNT_W-1:0]  delta  = cnt_q[rr_q] - seen_q[rr_q];
  wire [PROD_W-1:0] prod_d = PROD_W'(delta) * PROD_W'(wgt_q[rr_q]);

  assign rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         running_q <= 1'b0;
    else if (cmd_stop)  running_q <= 1'b0;
    else if (cmd_start) running_q <= 1'b1;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       cnt_q[i] <= '0;
      else if (cmd_clr) cnt_q[i] <= '0;
      else if (running_q && evt_i[i] && cnt_q[i] != '1)
        cnt_q[i] <= cnt_q[i] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen_q <= '0;
      rr_q   <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else if (cmd_clr) begin
      seen_q <= '0;
      rr_q   <= '0;
      prod_q <= '0;
      acc_q  <= '0;
    end else if (running_q) begin
      seen_q[rr_q] <= cnt_q[rr_q];
      rr_q   <= (rr_q == IDX_W'(NUM_EVT - 1)) ? '0 : rr_q + 1'b1;
      prod_q <= prod_d;
      acc_q  <= acc_q + ACC_W'(prod_q) + ACC_W'(wgt_q[NUM_EVT]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wgt_q <= '0;
    else if (wr_en && region == REG_W'(2) && slot <= SLOT_W'(NUM_EVT))
      wgt_q[slot] <= wdata[WGT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata_q   <= '0;
      hi_hold_q <= '0;
    end else if (rd_en) begin
      rdata_q <= '0;
      case (region)
        REG_W'(0): if (slot == SLOT_W'(1)) rdata_q <= DATA_W'(running_q);
        REG_W'(1): if (slot < SLOT_W'(NUM_EVT)) rdata_q <= DATA_W'(cnt_q[slot[IDX_W-1:0]]);
        REG_W'(2): if (slot <= SLOT_W'(NUM_EVT)) rdata_q <= DATA_W'(wgt_q[slot]);
        REG_W'(3): begin
          if (slot == SLOT_W'(0)) begin
            rdata_q   <= acc_q[DATA_W-1:0];
            hi_hold_q <= acc_q[ACC_W-1:DATA_W];
          end else if (slot == SLOT_W'(1)) begin
            rdata_q <= hi_hold_q;
          end
        end
        default: rdata_q <= '0;
      endcase
    end
endmodule

// File: rtl/act_power_est_chk.sv
module act_power_est_chk #(
  parameter int NUM_EVT = 36,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [ADDR_W-1:0]              addr,
  input logic [DATA_W-1:0]              wdata,
  input logic                           running_q,
  input logic [NUM_EVT-1:0][CNT_W-1:0]  cnt_q,
  input logic [2*DATA_W-1:0]            acc_q
);
  wire ctl  = wr_en && addr == '0;
  wire clr  = ctl && wdata[2];
  wire stop = ctl && wdata[1];
  wire go   = ctl && wdata[0];

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && cnt_q == '0)); // R3
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !running_q); // R3
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !stop) |=> running_q); // R3
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !clr) |=> ($stable(cnt_q) && $stable(acc_q))); // R4
  AST_ENERGY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !clr) |=> acc_q >= $past(acc_q)); // R8

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == '1 && !clr) |=> cnt_q[i] == '1); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q[i] - $past(cnt_q[i])) <= CNT_W'(1)); // R1
  end
endmodule

bind act_power_est act_power_est_chk #(
  .NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .running_q(running_q), .cnt_q(cnt_q), .acc_q(acc_q)
);

// File: tb/test_act_power_est.sv
`timescale 1ns/1ps
module test_act_power_est;
  localparam int NE = 36;
  localparam int CW = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;

  int n_chk = 0, n_bad = 0;
  bit m_run = 0;
  int m_cnt [NE];
  longint unsigned m_w [NE];
  longint unsigned m_ws = 0, run_edges = 0;
  logic [31:0] got, hi_old;

  // {expected tally 35 after the entry, repeat count, strobe mask}
  localparam logic [51:0] VEC [0:5] = '{
    {8'd0,  8'd5, 36'h0_0000_0001},
    {8'd3,  8'd3, 36'hF_0000_0000},
    {8'd10, 8'd7, 36'hA_AAAA_AAAA},
    {8'd10, 8'd4, 36'h5_5555_5555},
    {8'd10, 8'd9, 36'h0_FFFF_0000},
    {8'd12, 8'd2, 36'hF_FFFF_FFFF}
  };

  act_power_est #(.NUM_EVT(NE), .CNT_W(CW)) i_act_power_est (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit r, logic [11:0] a, logic [31:0] d, logic [NE-1:0] e);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; evt_i = e;
    @(posedge clk);
    if (m_run) begin
      run_edges++;
      for (int i = 0; i < NE; i++) if (e[i] && m_cnt[i] < CMAX) m_cnt[i]++;
    end
    if (w && a == 12'h000) begin
      if (d[2]) begin
        for (int i = 0; i < NE; i++) m_cnt[i] = 0;
        run_edges = 0;
      end
      if (d[1]) m_run = 0;
      else if (d[0]) m_run = 1;
    end
    if (w && a[11:8] == 4'h2 && a[7:2] < 6'(NE)) m_w[a[7:2]] = longint'(d[15:0]);
    if (w && a == 12'h200 + 12'(4 * NE)) m_ws = longint'(d[15:0]);
  endtask

  task automatic rd(logic [11:0] a);
    cyc(0, 1, a, 0, '0);
    #2 got = rdata;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, '0);
  endtask

  function automatic longint unsigned energy();
    longint unsigned e = m_ws * run_edges;
    for (int i = 0; i < NE; i++) e += longint'(m_cnt[i]) * m_w[i];
    return e;
  endfunction

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint unsigned e;
    for (int i = 0; i < NE; i++) begin m_cnt[i] = 0; m_w[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(12'h004); check("R11 status", got, 0);
    rd(12'h100); check("R11 tally0", got, 0);
    rd(12'h18C); check("R11 tally35", got, 0);
    rd(12'h21C); check("R11 weight7", got, 0);
    rd(12'h300); check("R11 energy lo", got, 0);
    rd(12'h304); check("R11 energy hi", got, 0);

    for (int i = 0; i < NE; i++) cyc(1, 0, 12'h200 + 12'(4*i), 32'(i*37+5), '0);
    cyc(1, 0, 12'h290, 32'hFFFF_0003, '0);
    rd(12'h228); check("R7 weight10", got, 32'(10*37+5));
    rd(12'h290); check("R7 static weight", got, 3);

    cyc(1, 0, 12'h000, 1, '0);
    rd(12'h004); check("R5 running", got, 1);

    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < int'(VEC[v][43:36]); k++) cyc(0, 0, 0, 0, VEC[v][35:0]);
      rd(12'h18C); check("R1 table tally35", got, 32'(VEC[v][51:44]));
    end
    idle(40);
    cyc(1, 0, 12'h000, 2, '0);
    rd(12'h004); check("R5 stopped", got, 0);
    for (int i = 0; i < NE; i++) begin
      rd(12'h100 + 12'(4*i)); check("R6 tally readback", got, 32'(m_cnt[i]));
    end
    e = energy();
    rd(12'h300); check("R8 energy lo", got, e[31:0]);
    rd(12'h304); check("R9 energy hi", got, e[63:32]);

    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, '1);
    rd(12'h100); check("R4 tally0 frozen", got, 32'(m_cnt[0]));
    rd(12'h300); check("R4 energy frozen", got, e[31:0]);

    rd(12'h000); check("R10 control reads zero", got, 0);
    rd(12'h190); check("R10 tally index NE", got, 0);
    rd(12'h294); check("R10 weight beyond static", got, 0);
    rd(12'h308); check("R10 energy gap", got, 0);
    rd(12'h400); check("R10 high region", got, 0);

    cyc(1, 0, 12'h000, 3, '0);
    rd(12'h004); check("R3 stop beats start", got, 0);

    cyc(1, 0, 12'h000, 5, 36'h10);
    rd(12'h004); check("R3 clear+start runs", got, 1);
    rd(12'h110); check("R3 cleared tally4", got, 0);
    cyc(0, 0, 0, 0, 36'h8);
    cyc(1, 0, 12'h000, 2, '0);
    rd(12'h10C); check("R3 count after clear+start", got, 1);
    rd(12'h110); check("R3 strobe in clear cycle", got, 0);

    cyc(1, 0, 12'h000, 4, '0);
    for (int i = 0; i <= NE; i++) cyc(1, 0, 12'h200 + 12'(4*i), 32'hFFFF, '0);
    cyc(1, 0, 12'h000, 1, '0);
    for (int k = 0; k < CMAX + 105; k++) cyc(0, 0, 0, 0, '1);
    idle(40);
    cyc(1, 0, 12'h000, 2, '0);
    rd(12'h100); check("R2 tally0 saturated", got, CMAX);
    rd(12'h18C); check("R2 tally35 saturated", got, CMAX);
    e = energy();
    rd(12'h300); check("R8 big energy lo", got, e[31:0]);
    hi_old = e[63:32];
    cyc(1, 0, 12'h000, 4, '0);
    rd(12'h304); check("R9 held high after clear", got, hi_old);
    rd(12'h300); check("R9 low after clear", got, 0);
    rd(12'h304); check("R9 high refreshed", got, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule